// File: doc/BRIEF.md
# Adjacency Memory Bubble Sorter

This block keeps the small table of incoming links of one node element. Each of the four entries holds a valid flag, a 7-bit start-node key and an 8-bit link weight. Before relaxation starts, a one-cycle start pulse launches a single bubble sort. The sort puts the entries in ascending key order, and each weight moves with its key. Entries marked invalid compare as larger than every valid entry, so they end up above the valid ones.

The sorter and the outside logic share one memory port. While the sort runs it owns that port. The rest of the time the port is open to outside loads and reads. The schedule is fixed: each compare-and-swap takes three cycles (fetch the lower entry, fetch the upper entry and compare, write both back in one edge). The sort therefore takes 3·D·(D−1)/2 cycles whatever the data holds, which is 18 cycles for D = 4.

The controller has five states:
- IDLE goes to FETCH_LO on an accepted start.
- FETCH_LO always goes to FETCH_HI.
- FETCH_HI always goes to STORE.
- STORE goes to FETCH_LO, or to FINISH after the last pair of the last pass.
- FINISH goes to IDLE.

Top module: `adj_sorter`

## Requirements
- R1: After reset, sort_busy and sort_done are both 0.
- R2: A sort_start seen at a clock edge while the block is in IDLE (busy and done both 0) raises sort_busy from that edge. sort_busy then stays high for exactly 3·D·(D−1)/2 cycles (18 for D = 4), whatever the memory holds.
- R3: sort_done is high for exactly one cycle, the cycle right after sort_busy falls, and is never high at the same time as sort_busy.
- R4: An entry word is {valid[15], key[14:8], weight[7:0]}. After the sort, valid entries are in ascending key order, and each weight stays with its original key.
- R5: Every entry with bit 15 equal to 0 ends up at a higher address than every entry with bit 15 equal to 1.
- R6: The sort is stable. Entries with equal keys keep their original relative order, and so do any two invalid entries.
- R7: sort_start is ignored while sort_busy or sort_done is high. It does not lengthen the run and does not launch a second run.
- R8: While idle, ext_we high at a clock edge writes ext_wdata to ext_addr, and ext_rdata shows the entry at ext_addr combinationally. While sort_busy is high, ext_we has no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sort_start | input | 1 | Pulse that launches a sort |
| sort_busy | output | 1 | High while the sort owns the memory port |
| sort_done | output | 1 | One-cycle pulse after the sort completes |
| ext_we | input | 1 | Write enable for the outside port |
| ext_addr | input | 2 | Entry address for the outside port |
| ext_wdata | input | 16 | Entry word to write |
| ext_rdata | output | 16 | Entry word at the port address |

## Verification
The hardest cases to reach are the ones where outside activity collides with a running sort. One is a second start arriving in the middle of a run or in the done cycle. Another is an outside write arriving while the sorter holds the port. The stimulus makes both happen on purpose. It pulses start and write-enable partway through the run and again in the done cycle. It then reads back the whole memory and compares each word with an independent stable sort computed in the bench. Patterns with duplicate keys and with invalid entries mixed in show whether weights travel with their keys and whether equal keys keep their order.

// File: rtl/adjsrt_pkg.sv
package adjsrt_pkg;
    localparam int unsigned KEY_W = 7;
    localparam int unsigned WGT_W = 8;
    localparam int unsigned ENT_W = 1 + KEY_W + WGT_W;

    typedef struct packed {
        logic             vld;
        logic [KEY_W-1:0] key;
        logic [WGT_W-1:0] wgt;
    } adj_ent_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_STORE,
        ST_FINISH
    } srt_state_e;
endpackage

// File: rtl/adjsrt_mem.sv
module adjsrt_mem #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic [AW-1:0]                addr,
    input  logic                         wr_en,
    input  logic [adjsrt_pkg::ENT_W-1:0] wr_data,
    input  logic                         pair_en,
    input  logic [adjsrt_pkg::ENT_W-1:0] pair_lo,
    input  logic [adjsrt_pkg::ENT_W-1:0] pair_hi,
    output logic [adjsrt_pkg::ENT_W-1:0] rd_data
);
    logic [adjsrt_pkg::ENT_W-1:0] store_q [DEPTH];
    logic [AW-1:0]                addr_up;

    assign addr_up = addr + 1'b1;
    assign rd_data = store_q[addr];

    // Pair write puts both halves of a compare-and-swap back in one edge.
    always_ff @(posedge clk) begin
        if (pair_en) begin
            store_q[addr]    <= pair_lo;
            store_q[addr_up] <= pair_hi;
        end else if (wr_en) begin
            store_q[addr] <= wr_data;
        end
    end
endmodule

// File: rtl/adjsrt_cmp.sv
module adjsrt_cmp
    import adjsrt_pkg::*;
(
    input  adj_ent_t ent_a,
    input  adj_ent_t ent_b,
    output adj_ent_t ent_lo,
    output adj_ent_t ent_hi
);
    logic a_after_b;

    // An invalid entry sits above every valid one. Equal keys never swap,
    // which keeps the sort stable.
    always_comb begin
        if (ent_a.vld) a_after_b = ent_b.vld && (ent_a.key > ent_b.key);
        else           a_after_b = ent_b.vld;
        ent_lo = a_after_b ? ent_b : ent_a;
        ent_hi = a_after_b ? ent_a : ent_b;
    end
endmodule

// File: rtl/adjsrt_ctrl.sv
module adjsrt_ctrl
    import adjsrt_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ENT_W-1:0] rd_data,
    output logic [AW-1:0]    sort_addr,
    output logic             pair_en,
    output logic [ENT_W-1:0] pair_lo,
    output logic [ENT_W-1:0] pair_hi,
    output logic             busy,
    output logic             done
);
    localparam logic [AW-1:0] LAST_PASS = AW'(DEPTH - 2);

    srt_state_e    state_q, state_d;
    logic [AW-1:0] pos_q, pass_q, last_pos;
    adj_ent_t      hold_q, lo_q, hi_q, cmp_lo, cmp_hi;
    logic          pair_last;

    assign last_pos  = LAST_PASS - pass_q;
    assign pair_last = (pos_q == last_pos) && (pass_q == LAST_PASS);

    adjsrt_cmp u_cmp (
        .ent_a (hold_q),
        .ent_b (adj_ent_t'(rd_data)),
        .ent_lo(cmp_lo),
        .ent_hi(cmp_hi)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_FETCH_LO;
            ST_FETCH_LO: state_d = ST_FETCH_HI;
            ST_FETCH_HI: state_d = ST_STORE;
            ST_STORE:    state_d = pair_last ? ST_FINISH : ST_FETCH_LO;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            pass_q <= '0;
            hold_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    pos_q  <= '0;
                    pass_q <= '0;
                end
                ST_FETCH_LO: hold_q <= adj_ent_t'(rd_data);
                ST_FETCH_HI: begin
                    lo_q <= cmp_lo;
                    hi_q <= cmp_hi;
                end
                ST_STORE: begin
                    if (pos_q == last_pos) begin
                        pos_q  <= '0;
                        pass_q <= pass_q + 1'b1;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        pair_en   = 1'b0;
        sort_addr = pos_q;
        unique case (state_q)
            ST_IDLE:     ;
            ST_FETCH_LO: busy = 1'b1;
            ST_FETCH_HI: begin
                busy      = 1'b1;
                sort_addr = pos_q + 1'b1;
            end
            ST_STORE: begin
                busy    = 1'b1;
                pair_en = 1'b1;
            end
            ST_FINISH:   done = 1'b1;
            default:     ;
        endcase
    end

    assign pair_lo = lo_q;
    assign pair_hi = hi_q;
endmodule

// File: rtl/adj_sorter.sv
module adj_sorter
    import adjsrt_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sort_start,
    output logic                     sort_busy,
    output logic                     sort_done,
    input  logic                     ext_we,
    input  logic [$clog2(DEPTH)-1:0] ext_addr,
    input  logic [ENT_W-1:0]         ext_wdata,
    output logic [ENT_W-1:0]         ext_rdata
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [AW-1:0]    sort_addr, mem_addr;
    logic             pair_en, mem_we;
    logic [ENT_W-1:0] pair_lo, pair_hi, rd_data;

    // The sorter owns the single port while busy; outside writes are dropped.
    assign mem_addr  = sort_busy ? sort_addr : ext_addr;
    assign mem_we    = ext_we && !sort_busy;
    assign ext_rdata = rd_data;

    adjsrt_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sort_start),
        .rd_data  (rd_data),
        .sort_addr(sort_addr),
        .pair_en  (pair_en),
        .pair_lo  (pair_lo),
        .pair_hi  (pair_hi),
        .busy     (sort_busy),
        .done     (sort_done)
    );

    adjsrt_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk    (clk),
        .addr   (mem_addr),
        .wr_en  (mem_we),
        .wr_data(ext_wdata),
        .pair_en(pair_en),
        .pair_lo(pair_lo),
        .pair_hi(pair_hi),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/adjsrt_chk.sv
module adjsrt_chk #(
    parameter int unsigned DEPTH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic mem_we
);
    localparam int unsigned RUN_CYC = 3 * DEPTH * (DEPTH - 1) / 2;

    int unsigned run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= 0;
        else if (busy) run_cnt <= run_cnt + 1;
        else           run_cnt <= 0;
    end

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    p_run_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == RUN_CYC));

    p_done_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_no_relaunch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_port_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_we);
endmodule

bind adj_sorter adjsrt_chk #(.DEPTH(DEPTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sort_start),
    .busy  (sort_busy),
    .done  (sort_done),
    .mem_we(mem_we)
);

// File: tb/adj_sorter_tb.sv
module adj_sorter_tb_top;
    localparam int D = 4;
    localparam int RUN = 3 * D * (D - 1) / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sort_start = 1'b0;
    logic        sort_busy, sort_done;
    logic        ext_we = 1'b0;
    logic [1:0]  ext_addr = '0;
    logic [15:0] ext_wdata = '0;
    logic [15:0] ext_rdata;

    int nchk = 0;
    int nfail = 0;

    // Reference timing model
    int m_rem = 0;
    bit m_done = 1'b0;

    always #5 clk = ~clk;

    adj_sorter #(.DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .sort_start(sort_start),
        .sort_busy(sort_busy), .sort_done(sort_done),
        .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0;
            m_done = 1'b0;
        end else if (m_rem > 0) begin
            m_done = (m_rem == 1);
            m_rem = m_rem - 1;
        end else if (sort_start && !m_done) begin
            m_rem = RUN;
            m_done = 1'b0;
        end else begin
            m_done = 1'b0;
        end
    end

    // Compare on every clock (R2 busy timing, R3 done pulse, R7 no relaunch)
    always @(negedge clk) begin
        if (rst_n) begin
            nchk++;
            if (sort_busy !== (m_rem > 0)) begin
                nfail++;
                $display("FAIL R2/R7 busy: actual %b expected %b", sort_busy, (m_rem > 0));
            end
            nchk++;
            if (sort_done !== m_done) begin
                nfail++;
                $display("FAIL R3 done: actual %b expected %b", sort_done, m_done);
            end
        end
    end

    function automatic bit goes_after(logic [15:0] a, logic [15:0] b);
        if (a[15]) return b[15] && (a[14:8] > b[14:8]);
        return b[15];
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(int a, logic [15:0] w);
        ext_we = 1'b1;
        ext_addr = 2'(a);
        ext_wdata = w;
        @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic run_case(string tag, logic [15:0] e0, logic [15:0] e1,
                            logic [15:0] e2, logic [15:0] e3,
                            bit mid_start, bit poke, bit done_start);
        logic [15:0] ref_q [4];
        logic [15:0] cur;
        int busy_seen;
        int k;
        ref_q[0] = e0; ref_q[1] = e1; ref_q[2] = e2; ref_q[3] = e3;
        put(0, e0); put(1, e1); put(2, e2); put(3, e3);
        for (int i = 0; i < 4; i++) begin
            ext_addr = 2'(i);
            #1;
            check({tag, " R8 load readback"}, ext_rdata, ref_q[i]);
        end
        // independent stable insertion sort
        for (int i = 1; i < 4; i++) begin
            int j;
            cur = ref_q[i];
            j = i - 1;
            while (j >= 0 && goes_after(ref_q[j], cur)) begin
                ref_q[j + 1] = ref_q[j];
                j--;
            end
            ref_q[j + 1] = cur;
        end
        @(negedge clk);
        sort_start = 1'b1;
        @(negedge clk);
        sort_start = 1'b0;
        busy_seen = 0;
        k = 0;
        while (!sort_done && k < 100) begin
            if (sort_busy) busy_seen++;
            if (mid_start && k == 5) sort_start = 1'b1;
            else sort_start = 1'b0;
            if (poke && k == 8) begin
                ext_we = 1'b1;
                ext_addr = 2'd0;
                ext_wdata = 16'hFFFF;
            end else begin
                ext_we = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        sort_start = 1'b0;
        ext_we = 1'b0;
        check({tag, " R2 busy cycle count"}, 16'(busy_seen), 16'(RUN));
        if (done_start) sort_start = 1'b1;
        @(negedge clk);
        sort_start = 1'b0;
        check({tag, " R7 idle after done"}, {15'd0, sort_busy}, 16'd0);
        for (int i = 0; i < 4; i++) begin
            ext_addr = 2'(i);
            #1;
            check({tag, " R4/R5/R6 sorted entry"}, ext_rdata, ref_q[i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R1 busy after reset", {15'd0, sort_busy}, 16'd0);
        check("R1 done after reset", {15'd0, sort_done}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reversed keys
        run_case("reverse", 16'hA811, 16'h9E22, 16'h9433, 16'h8A44, 1'b0, 1'b0, 1'b0);
        // R4 already ordered, R2 same time for any data
        run_case("ordered", 16'h8101, 16'h8202, 16'h8303, 16'h8404, 1'b0, 1'b0, 1'b0);
        // R5 invalid entries mixed in, R7 start mid-run
        run_case("invalid", 16'h7F55, 16'h8566, 16'h0077, 16'h8288, 1'b1, 1'b0, 1'b0);
        // R6 duplicate keys, R8 write during run, R7 start in done cycle
        run_case("dups", 16'h8701, 16'h8302, 16'h8703, 16'h8304, 1'b0, 1'b1, 1'b1);
        // R5/R6 all invalid keep order
        run_case("allinv", 16'h0510, 16'h0220, 16'h0630, 16'h0140, 1'b1, 1'b1, 1'b1);
        // R6 equal invalid and valid interleave
        run_case("mixdup", 16'h0000, 16'h8009, 16'h0001, 16'h8008, 1'b0, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule